// File: doc/BRIEF.md
# Windowed Key Watchdog

This block polices a firmware heartbeat with two timed windows in a fixed order. A closed window is followed by an open window. Firmware services the watchdog by presenting a key byte on a one-cycle write strobe. Only a matching key presented during the open window counts as a good service. A good service restarts the cycle at the start of the closed window.

Each of the following is a violation:
- a matching key presented while the window is still closed;
- any non-matching key presented during either window;
- the open window running out with no service.

Every violation latches a sticky flag for its cause and raises the interrupt. It can also raise a reset request. It emits a one-cycle power-down request to the sequencer, together with a two-bit shutdown mode captured from configuration at that moment.

Each window length comes from an 8-bit code c and lasts (c+1) ticks. A tick is `TICK_DIV` clock cycles. The default of 27000 cycles gives 3.375 ms per step at 8 MHz, so a window ranges from about 3.4 ms to 864 ms. After the watchdog is enabled, a grace phase of 1 or 8 full periods passes before any rule is enforced. One period is the closed window plus the open window. The watchdog returns to idle when it is disabled. It also returns to idle when sleep gating is selected and the system is asleep.

Top module: `win_wdog`

## Requirements
- R1: After reset, openWin, earlyFlag, keyFlag, missFlag, irq, rstReq and pdReq are 0 and pdMode is 0.
- R2: Once enforcing, a closed window of (cfgCloseCode+1)·TICK_DIV clocks is followed by an open window of (cfgOpenCode+1)·TICK_DIV clocks. openWin is 1 exactly during the open window.
- R3: After enable, a grace phase lasts G periods before the first closed window, where G=1 when cfgGraceSel is 0 and G=8 otherwise. One period is (cfgCloseCode+cfgOpenCode+2)·TICK_DIV clocks. Service writes during grace have no effect.
- R4: A write whose svcData equals cfgKey during the open window clears openWin on the next cycle, sets no flag, and starts a fresh closed window of full length.
- R5: A write whose svcData equals cfgKey during the closed window sets earlyFlag and restarts the closed window.
- R6: A write whose svcData differs from cfgKey during either window sets keyFlag and restarts at the closed window.
- R7: If the open window ends with no service, missFlag is set and a fresh closed window starts.
- R8: Every violation pulses pdReq for one cycle. In the same cycle pdMode takes the cfgPdMode value present at the violation, and pdMode holds that value until the next violation.
- R9: irq is 1 while any of earlyFlag, keyFlag or missFlag is set. rstReq equals irq AND cfgRstEn.
- R10: The flags stay set until flagClr is 1. A violation in the same cycle as flagClr leaves its flag set.
- R11: With cfgEnable at 0, or with cfgSleepGate and sleepIn both at 1, the watchdog is idle. In idle, openWin is 0 and no violation occurs. sleepIn has no effect while cfgSleepGate is 0.
- R12: Leaving idle starts a new grace phase from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Watchdog enable |
| cfgSleepGate | input | 1 | Idle the watchdog while sleepIn is 1 |
| sleepIn | input | 1 | System sleep indication |
| cfgCloseCode | input | 8 | Closed window length code |
| cfgOpenCode | input | 8 | Open window length code |
| cfgKey | input | 8 | Expected service key |
| cfgGraceSel | input | 3 | 0: one grace period, other: eight |
| cfgPdMode | input | 2 | Shutdown mode handed over on a violation |
| cfgRstEn | input | 1 | Allow faults to request a reset |
| svcValid | input | 1 | Service write strobe |
| svcData | input | 8 | Service write value |
| flagClr | input | 1 | Clear all violation flags |
| openWin | output | 1 | Open window currently active |
| earlyFlag | output | 1 | Sticky: good key during closed window |
| keyFlag | output | 1 | Sticky: wrong key written |
| missFlag | output | 1 | Sticky: open window ended unserviced |
| irq | output | 1 | Fault interrupt |
| rstReq | output | 1 | Fault reset request |
| pdReq | output | 1 | One-cycle forced power-down request |
| pdMode | output | 2 | Captured shutdown mode |

## Verification
The sweep covers every combination of three closed codes, two open codes and both grace lengths. For each one it measures three clock counts:
- enable to the first rise of openWin, which separates the grace length from the closed-window length;
- the width of openWin, which isolates the open code;
- the gap to the next rise after an unserviced window, which shows that the restart lands at the start of the closed window.

Half the sweep keeps sleepIn high without gating, to show that it is ignored. Directed writes then try the good and wrong key in each window and during grace. They tell the three violation causes apart, and a good service apart from a violation. Further cases cover a clear that coincides with a violation and changes of cfgPdMode after capture.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_GRACE_C = 3'd1,
    PH_GRACE_O = 3'd2,
    PH_CLOSED  = 3'd3,
    PH_OPEN    = 3'd4
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrTimers;   // restart prescaler and window counter
    logic countEn;     // prescaler runs
    logic useOpen;     // compare window counter with open code
    logic graceClr;    // reset grace period counter
    logic graceStep;   // one grace period finished
    logic capturePd;   // store shutdown mode
  } dpCtl_t;

endpackage

// File: rtl/win_wdog_dp.sv
module win_wdog_dp
  import win_wdog_pkg::*;
#(
  parameter int TICK_DIV   = 27000,
  parameter int CODE_W     = 8,
  parameter int KEY_W      = 8,
  parameter int MODE_W     = 2,
  parameter int GRACE_LONG = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              graceLong,
  input  logic [CODE_W-1:0] closeCode,
  input  logic [CODE_W-1:0] openCode,
  input  logic [KEY_W-1:0]  cfgKey,
  input  logic [KEY_W-1:0]  svcData,
  input  logic [MODE_W-1:0] cfgPdMode,
  output logic              winEnd,
  output logic              graceDone,
  output logic              keyMatch,
  output logic [MODE_W-1:0] pdMode
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int GC_W  = (GRACE_LONG > 1) ? $clog2(GRACE_LONG) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(TICK_DIV - 1);
  localparam logic [GC_W-1:0]  GRACE_LAST = GC_W'(GRACE_LONG - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [CODE_W-1:0] winCnt;
  logic [GC_W-1:0]   graceCnt;
  logic [CODE_W-1:0] curCode;
  logic              tick;

  assign tick    = ctl.countEn && (preCnt == PRE_LAST);
  assign curCode = ctl.useOpen ? openCode : closeCode;
  assign winEnd  = tick && (winCnt == curCode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (ctl.clrTimers) begin
      preCnt <= '0;
    end else if (tick) begin
      preCnt <= '0;
    end else if (ctl.countEn) begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (ctl.clrTimers) begin
      winCnt <= '0;
    end else if (tick) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      graceCnt <= '0;
    end else if (ctl.graceClr) begin
      graceCnt <= '0;
    end else if (ctl.graceStep) begin
      graceCnt <= graceCnt + 1'b1;
    end
  end

  assign graceDone = graceLong ? (graceCnt == GRACE_LAST) : 1'b1;

  assign keyMatch = (svcData == cfgKey);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdMode <= '0;
    end else if (ctl.capturePd) begin
      pdMode <= cfgPdMode;
    end
  end

endmodule

// File: rtl/win_wdog_ctrl.sv
module win_wdog_ctrl
  import win_wdog_pkg::*;
#(
  parameter int GRACE_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgSleepGate,
  input  logic               sleepIn,
  input  logic [GRACE_W-1:0] cfgGraceSel,
  input  logic               svcValid,
  input  logic               flagClr,
  input  logic               winEnd,
  input  logic               graceDone,
  input  logic               keyMatch,
  output dpCtl_t             ctl,
  output logic               graceLong,
  output logic               openWin,
  output logic               earlyFlag,
  output logic               keyFlag,
  output logic               missFlag,
  output logic               pdReq
);

  phase_e phase, phaseNxt;
  logic   active;
  logic   earlyEv, keyEv, missEv, anyEv;

  assign active    = cfgEnable && !(cfgSleepGate && sleepIn);
  assign graceLong = (cfgGraceSel != '0);

  always_comb begin
    phaseNxt = phase;
    ctl      = '0;
    earlyEv  = 1'b0;
    keyEv    = 1'b0;
    missEv   = 1'b0;
    ctl.countEn = (phase != PH_IDLE);
    ctl.useOpen = (phase == PH_GRACE_O) || (phase == PH_OPEN);
    if (!active) begin
      phaseNxt      = PH_IDLE;
      ctl.clrTimers = 1'b1;
      ctl.graceClr  = 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          phaseNxt      = PH_GRACE_C;
          ctl.clrTimers = 1'b1;
          ctl.graceClr  = 1'b1;
        end
        PH_GRACE_C: begin
          if (winEnd) begin
            phaseNxt      = PH_GRACE_O;
            ctl.clrTimers = 1'b1;
          end
        end
        PH_GRACE_O: begin
          if (winEnd) begin
            ctl.clrTimers = 1'b1;
            if (graceDone) begin
              phaseNxt = PH_CLOSED;
            end else begin
              phaseNxt      = PH_GRACE_C;
              ctl.graceStep = 1'b1;
            end
          end
        end
        PH_CLOSED: begin
          if (svcValid) begin
            ctl.clrTimers = 1'b1;
            earlyEv       = keyMatch;
            keyEv         = !keyMatch;
          end else if (winEnd) begin
            phaseNxt      = PH_OPEN;
            ctl.clrTimers = 1'b1;
          end
        end
        PH_OPEN: begin
          if (svcValid) begin
            phaseNxt      = PH_CLOSED;
            ctl.clrTimers = 1'b1;
            keyEv         = !keyMatch;
          end else if (winEnd) begin
            phaseNxt      = PH_CLOSED;
            ctl.clrTimers = 1'b1;
            missEv        = 1'b1;
          end
        end
        default: begin
          phaseNxt      = PH_IDLE;
          ctl.clrTimers = 1'b1;
          ctl.graceClr  = 1'b1;
        end
      endcase
    end
    anyEv         = earlyEv || keyEv || missEv;
    ctl.capturePd = anyEv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      earlyFlag <= 1'b0;
      keyFlag   <= 1'b0;
      missFlag  <= 1'b0;
      pdReq     <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      earlyFlag <= (earlyFlag && !flagClr) || earlyEv;
      keyFlag   <= (keyFlag && !flagClr) || keyEv;
      missFlag  <= (missFlag && !flagClr) || missEv;
      pdReq     <= anyEv;
    end
  end

  assign openWin = (phase == PH_OPEN);

endmodule

// File: rtl/win_wdog.sv
module win_wdog
  import win_wdog_pkg::*;
#(
  parameter int TICK_DIV   = 27000,
  parameter int CODE_W     = 8,
  parameter int KEY_W      = 8,
  parameter int MODE_W     = 2,
  parameter int GRACE_W    = 3,
  parameter int GRACE_LONG = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgEnable,
  input  logic               cfgSleepGate,
  input  logic               sleepIn,
  input  logic [CODE_W-1:0]  cfgCloseCode,
  input  logic [CODE_W-1:0]  cfgOpenCode,
  input  logic [KEY_W-1:0]   cfgKey,
  input  logic [GRACE_W-1:0] cfgGraceSel,
  input  logic [MODE_W-1:0]  cfgPdMode,
  input  logic               cfgRstEn,
  input  logic               svcValid,
  input  logic [KEY_W-1:0]   svcData,
  input  logic               flagClr,
  output logic               openWin,
  output logic               earlyFlag,
  output logic               keyFlag,
  output logic               missFlag,
  output logic               irq,
  output logic               rstReq,
  output logic               pdReq,
  output logic [MODE_W-1:0]  pdMode
);

  dpCtl_t ctl;
  logic   winEnd, graceDone, keyMatch, graceLong;

  win_wdog_ctrl #(.GRACE_W(GRACE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgSleepGate(cfgSleepGate),
    .sleepIn(sleepIn), .cfgGraceSel(cfgGraceSel), .svcValid(svcValid),
    .flagClr(flagClr), .winEnd(winEnd), .graceDone(graceDone), .keyMatch(keyMatch),
    .ctl(ctl), .graceLong(graceLong), .openWin(openWin), .earlyFlag(earlyFlag),
    .keyFlag(keyFlag), .missFlag(missFlag), .pdReq(pdReq)
  );

  win_wdog_dp #(
    .TICK_DIV(TICK_DIV), .CODE_W(CODE_W), .KEY_W(KEY_W),
    .MODE_W(MODE_W), .GRACE_LONG(GRACE_LONG)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .graceLong(graceLong),
    .closeCode(cfgCloseCode), .openCode(cfgOpenCode), .cfgKey(cfgKey),
    .svcData(svcData), .cfgPdMode(cfgPdMode), .winEnd(winEnd),
    .graceDone(graceDone), .keyMatch(keyMatch), .pdMode(pdMode)
  );

  assign irq    = earlyFlag || keyFlag || missFlag;
  assign rstReq = irq && cfgRstEn;

endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk #(
  parameter int MODE_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgEnable,
  input logic              cfgSleepGate,
  input logic              sleepIn,
  input logic              flagClr,
  input logic              openWin,
  input logic              missFlag,
  input logic              irq,
  input logic              pdReq,
  input logic [MODE_W-1:0] pdMode
);

  logic idleReq;
  assign idleReq = !cfgEnable || (cfgSleepGate && sleepIn);

  AST_PD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    pdReq |-> irq);                                   // R9
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !pdReq |-> $stable(pdMode));                      // R8
  AST_IDLE_NO_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> !openWin);                            // R11
  AST_IDLE_NO_PD: assert property (@(posedge clk) disable iff (!rstN)
    idleReq |=> !pdReq);                              // R11
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !flagClr) |=> irq);                       // R10
  AST_MISS_FROM_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(missFlag) |-> $past(openWin));              // R7

endmodule

bind win_wdog win_wdog_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgSleepGate(cfgSleepGate),
  .sleepIn(sleepIn), .flagClr(flagClr), .openWin(openWin), .missFlag(missFlag),
  .irq(irq), .pdReq(pdReq), .pdMode(pdMode)
);

// File: tb/win_wdog_bench.sv
module win_wdog_bench;

  localparam int D = 2;
  localparam int LIM = 5000;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgEnable = 0, cfgSleepGate = 0, sleepIn = 0, cfgRstEn = 0;
  logic [7:0] cfgCloseCode = 0, cfgOpenCode = 0, cfgKey = 8'h5A, svcData = 0;
  logic [2:0] cfgGraceSel = 0;
  logic [1:0] cfgPdMode = 0;
  logic svcValid = 0, flagClr = 0;
  logic openWin, earlyFlag, keyFlag, missFlag, irq, rstReq, pdReq;
  logic [1:0] pdMode;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  win_wdog #(.TICK_DIV(D)) u_win_wdog (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgSleepGate(cfgSleepGate),
    .sleepIn(sleepIn), .cfgCloseCode(cfgCloseCode), .cfgOpenCode(cfgOpenCode),
    .cfgKey(cfgKey), .cfgGraceSel(cfgGraceSel), .cfgPdMode(cfgPdMode),
    .cfgRstEn(cfgRstEn), .svcValid(svcValid), .svcData(svcData), .flagClr(flagClr),
    .openWin(openWin), .earlyFlag(earlyFlag), .keyFlag(keyFlag), .missFlag(missFlag),
    .irq(irq), .rstReq(rstReq), .pdReq(pdReq), .pdMode(pdMode)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitOpen(logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (openWin !== lvl && n < LIM);
  endtask

  task automatic svc(logic [7:0] v);
    svcValid = 1'b1;
    svcData  = v;
    @(negedge clk);
    svcValid = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic doReset();
    cfgEnable = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  function automatic int firstOpen(int c, int o, int g);
    int gp;
    gp = (g == 0) ? 1 : 8;
    return (gp * (c + o + 2) + c + 1) * D + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n, it, cc, oc;
    int cs[3];
    int os[2];
    cs = '{0, 1, 3};
    os = '{0, 2};
    it = 0;

    // R1 reset state
    @(negedge clk);
    @(negedge clk);
    chk("R1 openWin", openWin, 0);
    chk("R1 flags", {earlyFlag, keyFlag, missFlag}, 0);
    chk("R1 irq/rstReq/pdReq", {irq, rstReq, pdReq}, 0);
    chk("R1 pdMode", pdMode, 0);
    rstN = 1'b1;

    // Sweep: R2, R3, R7, R8, R11 (ungated sleep ignored)
    foreach (cs[i]) foreach (os[j]) for (int g = 0; g < 2; g++) begin
      cc = cs[i];
      oc = os[j];
      doReset();
      cfgCloseCode = 8'(cc);
      cfgOpenCode  = 8'(oc);
      cfgGraceSel  = (g == 0) ? 3'd0 : 3'd5;
      cfgPdMode    = 2'(it);
      cfgSleepGate = 1'b0;
      sleepIn      = it[0];
      cfgEnable    = 1'b1;
      waitOpen(1'b1, n);
      chk("R3 R11 first open", n, firstOpen(cc, oc, g));
      waitOpen(1'b0, n);
      chk("R2 open width", n, (oc + 1) * D);
      chk("R7 miss flag", missFlag, 1);
      chk("R8 pdReq pulse", pdReq, 1);
      chk("R8 pdMode", pdMode, it % 4);
      @(negedge clk);
      chk("R8 pdReq one cycle", pdReq, 0);
      waitOpen(1'b1, n);
      chk("R2 R7 closed restart", n, (cc + 1) * D - 1);
      it++;
    end

    // Directed: c=1, o=2, one grace period
    sleepIn = 1'b0;
    doReset();
    cfgCloseCode = 8'd1;
    cfgOpenCode  = 8'd2;
    cfgGraceSel  = 3'd0;
    cfgPdMode    = 2'd2;
    cfgRstEn     = 1'b1;
    cfgEnable    = 1'b1;
    @(negedge clk);
    svc(8'h5A);
    svc(8'h11);
    chk("R3 grace writes ignored", {earlyFlag, keyFlag, missFlag, pdReq}, 0);
    waitOpen(1'b1, n);
    chk("R3 open after ignored writes", n + 3, firstOpen(1, 2, 0));

    svc(8'h5A);
    chk("R4 good service closes", openWin, 0);
    chk("R4 no flags", {irq, pdReq}, 0);
    waitOpen(1'b1, n);
    chk("R4 full closed window", n, 2 * D);

    svc(8'h5A);                 // good service -> closed
    svc(8'h5A);                 // good key while closed
    chk("R5 early flag", earlyFlag, 1);
    chk("R5 only early", {keyFlag, missFlag}, 0);
    chk("R8 pdReq early", pdReq, 1);
    chk("R9 irq", irq, 1);
    chk("R9 rstReq", rstReq, 1);
    cfgPdMode = 2'd1;
    @(negedge clk);
    chk("R8 pdMode held", pdMode, 2);
    waitOpen(1'b1, n);
    chk("R5 restart closed", n, 2 * D - 1);
    pulseClr();
    chk("R10 clear", {earlyFlag, keyFlag, missFlag, irq}, 0);

    cfgRstEn = 1'b0;
    svc(8'hA5);                 // wrong key while open
    chk("R6 key flag open", keyFlag, 1);
    chk("R6 no early", earlyFlag, 0);
    chk("R8 new pdMode", pdMode, 1);
    chk("R9 rstReq gated", rstReq, 0);
    chk("R9 irq on key", irq, 1);
    pulseClr();
    flagClr = 1'b1;             // clear coincides with wrong key while closed
    svc(8'h00);
    flagClr = 1'b0;
    chk("R10 violation beats clear", keyFlag, 1);
    chk("R6 key flag closed", openWin, 0);
    pulseClr();

    // R11 gated sleep
    cfgSleepGate = 1'b1;
    sleepIn = 1'b1;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n += openWin + pdReq + irq;
    end
    chk("R11 sleep idle", n, 0);
    sleepIn = 1'b0;
    waitOpen(1'b1, n);
    chk("R12 new grace after sleep", n, firstOpen(1, 2, 0));

    // R11 disable
    cfgEnable = 1'b0;
    @(negedge clk);
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      n += openWin + pdReq + irq;
    end
    chk("R11 disabled idle", n, 0);
    cfgGraceSel = 3'd1;
    cfgEnable = 1'b1;
    waitOpen(1'b1, n);
    chk("R12 long grace on re-enable", n, firstOpen(1, 2, 1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule